// File: doc/BRIEF.md
# Bus-Mapped GPIO Port Register

This block is an 8-bit general-purpose I/O port that sits on a simple synchronous register bus. It has two registers: a port data register and a data direction register. Each has its own bus address. The six upper bits can drive their pins. When such a bit's direction is set, its pin is driven from the data register. The two lowest bits only ever sample their pins. Pin inputs pass through a two-flop synchronizer before they can be read or captured.

A read of the data register is assembled bit by bit. A bit configured as an output returns the stored value. A bit configured as an input, and every input-only bit, returns the synchronized pin. Read data is registered.

The data register clears on reset. On the second clock edge after reset is released, it loads the synchronized pin states. A bus write in that same cycle wins over the capture. When the emulation input is high, the local registers and pins no longer supply read data; the external bus read data is returned instead. Writes still update the local registers and are also passed on to the external bus.

Top module: `gpio_port_reg`

## Requirements
- R1: While reset is held, pin_out and pin_oe are all zeros. Both the data register and the direction register are zero.
- R2: Count the rising edges with rst_n high, starting at 1. The data register holds zero through edge 1. At edge 2 it loads the synchronized pin values, so pin_out[7:2] equals the pins after that edge.
- R3: A data-register write that lands on the capture edge takes priority: the written value is stored, not the pins.
- R4: bus_addr 0 selects the data register and bus_addr 1 the direction register. A write (bus_sel=1, bus_wr=1) stores bus_wdata at the next edge. A read of address 1 returns all 8 stored direction bits.
- R5: For bits 7..2, a read of address 0 returns the stored data bit when its direction bit is 1. When the direction bit is 0, it returns the pin value, provided the pin has been stable for at least two clock edges.
- R6: Bits 1 and 0 are input-only. Their pin_oe and pin_out bits are always 0. A read of address 0 returns their pin values whatever the direction bits hold.
- R7: For bits 7..2, pin_out equals the data register bit and pin_oe equals the direction bit.
- R8: bus_rdata changes only on the edge that samples a read strobe (bus_sel=1, bus_wr=0). It is valid from that edge on and holds its value until the next read.
- R9: With emu_mode=1, a read returns ext_rdata as sampled on the strobe edge, whatever the address.
- R10: With emu_mode=1, a write still updates the local register. In the same cycle, ext_wr is 1 and ext_addr/ext_wdata carry the bus address and data. ext_wr and ext_rd are 0 whenever emu_mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = direction register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| emu_mode | input | 1 | Redirects accesses to the external bus |
| ext_wr | output | 1 | Forwarded write strobe |
| ext_rd | output | 1 | Forwarded read strobe |
| ext_addr | output | 1 | Forwarded address |
| ext_wdata | output | 8 | Forwarded write data |
| ext_rdata | input | 8 | External bus read data |
| pin_in | input | 8 | Raw pin inputs |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The embedded assertions check four things on every cycle:
- the capture pulse fires only once per reset release;
- a write on the capture edge wins;
- the data register does not move without a write or capture;
- read data holds between reads, input-only bits read their synchronized pins, and emulation reads return the external data.

Other behaviour can only be shown by the bench's scenarios:
- the exact edge at which the post-reset capture happens;
- the direction-dependent read mix after pin changes;
- that direction bits 1..0 are ignored at the pins;
- that writes made in emulation mode reach the local registers.

// File: rtl/gpio_port_pkg.sv
// Shared address and type definitions for the GPIO port register block.
// Assumes a one-bit register address space with two registers.
package gpio_port_pkg;
    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } gpio_reg_e;
endpackage

// File: rtl/gpio_port_sync.sv
// Multi-stage synchronizer for the raw pin inputs.
// Assumes pins are asynchronous. The stages carry no reset so that the
// post-reset capture sees settled pin values.
module gpio_port_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the raw pins
    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-registers the previous one
        always_ff @(posedge clk) begin
            stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_capture.sv
// Generates a single-cycle pulse on the DELAY-th clock edge after reset
// is released. Assumes DELAY >= 1. The counter saturates, so the pulse
// fires once per reset release.
module gpio_port_capture #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic cap_pulse
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    // Count edges after reset release up to DELAY, then hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != CW'(DELAY))
            cnt <= cnt + 1'b1;
    end

    assign cap_pulse = rst_n && (cnt == CW'(DELAY - 1));

    // R2
    capture_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> !cap_pulse);
endmodule

// File: rtl/gpio_port_regs.sv
// Data and direction register storage. A bus write to the data register
// takes priority over the post-reset pin capture. Assumes the write
// strobes are mutually exclusive.
module gpio_port_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wdata,
    input  logic             cap,
    input  logic [WIDTH-1:0] cap_val,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q
);
    // Data register: clear, then bus write over capture
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (wr_data)
            data_q <= wdata;
        else if (cap)
            data_q <= cap_val;
    end

    // Direction register: clear, then bus write
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_dir)
            dir_q <= wdata;
    end

    // R3
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && cap) |=> data_q == $past(wdata));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_data && !cap) |=> $stable(data_q));
endmodule

// File: rtl/gpio_port_reg.sv
// Top of the 8-bit bus-mapped GPIO port. Decodes bus accesses, builds the
// direction-dependent read value, drives pin outputs and enables, and
// forwards accesses to an external bus in emulation mode. Assumes the low
// IN_ONLY bits are input-only pins.
module gpio_port_reg
    import gpio_port_pkg::*;
#(
    parameter int WIDTH         = 8,
    parameter int IN_ONLY       = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int CAPTURE_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic             emu_mode,
    output logic             ext_wr,
    output logic             ext_rd,
    output logic             ext_addr,
    output logic [WIDTH-1:0] ext_wdata,
    input  logic [WIDTH-1:0] ext_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] port_view;
    logic [WIDTH-1:0] local_rd;
    logic             cap;
    logic             wr_en;
    logic             rd_en;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_port_capture #(.DELAY(CAPTURE_DELAY)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pulse (cap)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_en && (bus_addr == REG_DATA)),
        .wr_dir  (wr_en && (bus_addr == REG_DIR)),
        .wdata   (bus_wdata),
        .cap     (cap),
        .cap_val (pin_sync),
        .data_q  (data_q),
        .dir_q   (dir_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < IN_ONLY) begin : g_in_only
            assign port_view[i] = pin_sync[i];
            assign pin_out[i]   = 1'b0;
            assign pin_oe[i]    = 1'b0;
        end else begin : g_bidir
            assign port_view[i] = dir_q[i] ? data_q[i] : pin_sync[i];
            assign pin_out[i]   = data_q[i];
            assign pin_oe[i]    = dir_q[i];
        end
    end

    assign local_rd = (bus_addr == REG_DIR) ? dir_q : port_view;

    // Register read data on the strobe edge, from local or external source
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= emu_mode ? ext_rdata : local_rd;
    end

    assign ext_wr    = emu_mode && wr_en;
    assign ext_rd    = emu_mode && rd_en;
    assign ext_addr  = bus_addr;
    assign ext_wdata = bus_wdata;

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));

    // R6
    in_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !emu_mode && bus_addr == REG_DATA)
        |=> bus_rdata[IN_ONLY-1:0] == $past(pin_sync[IN_ONLY-1:0]));

    // R9
    emu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && emu_mode) |=> bus_rdata == $past(ext_rdata));
endmodule

// File: tb/gpio_port_reg_tb.sv
module gpio_port_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       emu_mode = 1'b0;
    logic       ext_wr, ext_rd, ext_addr;
    logic [7:0] ext_wdata;
    logic [7:0] ext_rdata = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_data, m_dir;

    always #2.5 clk = ~clk;

    gpio_port_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .emu_mode(emu_mode), .ext_wr(ext_wr), .ext_rd(ext_rd),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_port(input logic [7:0] d, input logic [7:0] dir,
                                            input logic [7:0] p);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = (i >= 2 && dir[i]) ? d[i] : p[i];
        return r;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        #1;
        check(emu_mode ? "R10 ext_wr" : "R10 ext_wr off", ext_wr, emu_mode);
        if (emu_mode) check("R10 ext fwd", {ext_addr, ext_wdata}, {a, v});
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (a) m_dir = v; else m_data = v;
        check("R7 pin_out", pin_out, m_data & 8'hFC);
        check("R6/R7 pin_oe", pin_oe, m_dir & 8'hFC);
    endtask

    task automatic bus_read(input logic a, input string req);
        logic [7:0] exp;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        if (emu_mode) exp = ext_rdata;
        else exp = a ? m_dir : exp_port(m_data, m_dir, pin_in);
        @(negedge clk);
        bus_sel = 0;
        check(req, bus_rdata, exp);
        idle(1);
        check("R8 hold", bus_rdata, exp);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        // R1: reset state
        pin_in = 8'hB6;
        idle(4);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        // R2: capture on second edge after release
        rst_n = 1;
        idle(1);
        check("R2 before capture", pin_out, 8'h00);
        idle(1);
        check("R2 captured", pin_out, 8'hB4);
        m_data = 8'hB6; m_dir = 8'h00;
        bus_write(1'b1, 8'hFF);
        bus_read(1'b0, "R5 read all out");
        bus_read(1'b1, "R4 dir readback");

        // R3: write on capture edge wins
        @(negedge clk); rst_n = 0; pin_in = 8'h3C;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'hC3;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        check("R3 write wins", pin_out, 8'hC0);
        idle(2);
        check("R3 stays", pin_out, 8'hC0);
        m_data = 8'hC3; m_dir = 8'h00;

        // R6: low direction bits ignored
        bus_write(1'b1, 8'h03);
        check("R6 oe low", pin_oe, 8'h00);
        pin_in = 8'h02; idle(3);
        bus_read(1'b0, "R6 low bits from pins");

        // R5: mixed direction
        bus_write(1'b1, 8'hA5);
        bus_write(1'b0, 8'h5A);
        pin_in = 8'hF0; idle(3);
        bus_read(1'b0, "R5 mixed");

        // R9/R10: emulation
        emu_mode = 1; ext_rdata = 8'h99;
        bus_read(1'b0, "R9 emu read");
        bus_write(1'b0, 8'h77);
        emu_mode = 0;
        bus_read(1'b0, "R10 local updated");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 4);
            emu_mode = ($urandom_range(0, 5) == 0);
            ext_rdata = 8'($urandom);
            case (op)
                0: bus_write(1'b0, 8'($urandom));
                1: bus_write(1'b1, 8'($urandom));
                2: bus_read(1'b0, emu_mode ? "R9 rand" : "R5 rand");
                3: bus_read(1'b1, emu_mode ? "R9 rand" : "R4 rand");
                default: begin pin_in = 8'($urandom); idle(3); end
            endcase
        end
        emu_mode = 0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule